// File: doc/BRIEF.md
# Parallel-Move Multiply-Accumulate Sequencer Core

This core runs small microprograms from an internal 64-word instruction store. Its datapath has four 64-word data banks. Each bank is read or written through its own port, and the address comes from a 6-bit pointer that steps forward by one after every access. The banks feed a 32-bit X register and a 32-bit Y register. The signed product of X and Y goes into a 48-bit product register P, and the ALU combines P with a 48-bit accumulator A.

A single operation word can do several things in the same cycle: an X load, a Y load, a P load, an A load or clear, an ALU operation and one general move. Every part of the word reads the register values from before that word. Because of this, a sum of products streams at one term per word.

The program can also do these things:
- load constants,
- repeat the next word a counted number of times,
- start a stand-in external transfer and spin on its busy flag,
- stop, with or without a one-cycle done pulse.

A host loads the instruction store and the data banks through plain write ports while the core is idle, pulses `start`, and reads results back after `running` falls.

Top module: `mac_dsp_core`

## Requirements
- R1: After reset, `running`, `irq` and `xfer_busy` are low and `ext_byte_addr` is 0.
- R2: Each pointer is 6 bits. Every word that reads or writes bank n through its port uses pointer n and then adds one to it, wrapping from 63 to 0. Loading pointer n in the same word takes priority over the step. Pointers do not change while the core is idle.
- R3: A constant-load word has bits 31:30 = 01, a destination in 29:26 and a zero-extended constant in 25:0. The destination codes are: 0–3 bank n port, 4–7 pointer n, 8 X, 9 Y, 10 repeat count, 11 transfer address.
- R4: An operation word has bits 31:30 = 00 and these fields:
  - 29:26 ALU code;
  - 25 X load enable, with source bank in 24:23;
  - 22 Y load enable, with source bank in 21:20;
  - 19 P load;
  - 18:17 A control (1 = ALU result, 2 = clear);
  - 16:14 move kind (1 = bank port in 9:8, 2 = constant in 7:0, 3 = ALU low 32 bits);
  - 13:10 move destination, using the R3 codes.

  All fields act in the same cycle and read pre-word values. A move to X or Y wins over the X or Y load in the same word.
- R5: A P load stores the low 48 bits of the signed product of X and Y.
- R6: ALU code 6 adds the full 48-bit A and P. Move kind 3 writes bits 31:0 of the ALU result to the destination, so that the terms 2×3 and 4×5 give 26.
- R7: A control 2 zeroes all 48 bits of A in the same word as the other moves.
- R8: ALU codes 1 to 5 (AND, OR, XOR, ADD, SUB as A minus P) act on bits 31:0 of A and P and keep A bits 47:32. Code 0 passes A unchanged.
- R9: A control word has bits 31:30 = 10 and a kind in 29:27. Kind 3 executes the next word (repeat count + 1) times, decrementing the count on each repeat, and then continues.
- R10: Control kind 6 with a count c in bits 7:0, issued while not busy, holds `xfer_busy` high for c cycles. During each of those cycles the transfer address register advances by one 4-byte unit. `ext_byte_addr` is that register times 4, and loads into it are ignored while busy.
- R11: Control kinds 0, 1 and 2 jump to the address in bits 5:0: kind 0 always, kind 1 while busy, kind 2 while not busy. Otherwise execution falls through.
- R12: Control kind 4 stops execution. Kind 5 stops and pulses `irq` high for exactly one cycle, in the cycle `running` goes low.
- R13: Host writes to the data banks take effect only while the core is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at address 0 (while idle) |
| prog_we | input | 1 | Instruction store write enable (while idle) |
| prog_addr | input | PAW | Instruction store address |
| prog_data | input | 32 | Instruction word |
| host_we | input | 1 | Data bank write enable (while idle) |
| host_bank | input | 2 | Bank selected by the host |
| host_addr | input | AW | Word address within the bank |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Combinational read of the selected word |
| running | output | 1 | Program executing |
| irq | output | 1 | One-cycle done pulse |
| xfer_busy | output | 1 | Stand-in transfer in progress |
| ext_byte_addr | output | RAW+2 | Transfer address in bytes |

## Verification
The assertions check four rules on every cycle:
- the done pulse lasts one cycle and coincides with the stop;
- each busy cycle moves the transfer address by exactly four bytes;
- a repeat holds the program counter and lowers the count;
- pointers stay still while idle.

Only the bench scenarios can show the arithmetic and the data movement:
- the same-cycle use of pre-word values in a streamed sum of products, swept over signed operands;
- the effect of each ALU code;
- the exact words copied by a repeated move, and the cycle count of the run;
- pointer wrap;
- the fall-through timing of the busy spin loop.

// File: rtl/mac_dsp_core.sv
module mac_dsp_core #(
  parameter int DW  = 32,
  parameter int PW  = 48,
  parameter int AW  = 6,
  parameter int PAW = 6,
  parameter int LW  = 8,
  parameter int RAW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           prog_we,
  input  logic [PAW-1:0] prog_addr,
  input  logic [31:0]    prog_data,
  input  logic           host_we,
  input  logic [1:0]     host_bank,
  input  logic [AW-1:0]  host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           running,
  output logic           irq,
  output logic           xfer_busy,
  output logic [RAW+1:0] ext_byte_addr
);
  localparam int DEPTH  = 1 << AW;
  localparam int PDEPTH = 1 << PAW;

  logic [31:0]    imem [PDEPTH];
  logic [DW-1:0]  ram  [4][DEPTH];
  logic [AW-1:0]  ct_q [4];
  logic [DW-1:0]  x_q, y_q;
  logic [PW-1:0]  p_q, a_q;
  logic [LW-1:0]  lop_q;
  logic [RAW-1:0] ra_q;
  logic [7:0]     xcnt_q;
  logic           run_q, irq_q, rpt_q;
  logic [PAW-1:0] pc_q;

  wire [31:0] ins    = imem[pc_q];
  wire        is_op  = run_q && ins[31:30] == 2'b00;
  wire        is_mvi = run_q && ins[31:30] == 2'b01;
  wire        is_ctl = run_q && ins[31:30] == 2'b10;

  wire [3:0] aop   = ins[29:26];
  wire       xen   = ins[25];
  wire [1:0] xs    = ins[24:23];
  wire       yen   = ins[22];
  wire [1:0] ys    = ins[21:20];
  wire       pld   = ins[19];
  wire [1:0] actl  = ins[18:17];
  wire [2:0] d1op  = ins[16:14];
  wire [3:0] d1dst = ins[13:10];
  wire [1:0] d1src = ins[9:8];
  wire [7:0] imm8  = ins[7:0];
  wire [2:0] csub  = ins[29:27];

  assign xfer_busy = xcnt_q != 8'd0;

  wire [DW-1:0] rd_x = ram[xs][ct_q[xs]];
  wire [DW-1:0] rd_y = ram[ys][ct_q[ys]];
  wire [DW-1:0] rd_d = ram[d1src][ct_q[d1src]];

  logic signed [PW-1:0] prod;
  assign prod = $signed(x_q) * $signed(y_q);

  logic [PW-1:0] alu;
  always_comb begin
    alu = a_q;
    case (aop)
      4'd1: alu = {a_q[PW-1:DW], a_q[DW-1:0] & p_q[DW-1:0]};
      4'd2: alu = {a_q[PW-1:DW], a_q[DW-1:0] | p_q[DW-1:0]};
      4'd3: alu = {a_q[PW-1:DW], a_q[DW-1:0] ^ p_q[DW-1:0]};
      4'd4: alu = {a_q[PW-1:DW], a_q[DW-1:0] + p_q[DW-1:0]};
      4'd5: alu = {a_q[PW-1:DW], a_q[DW-1:0] - p_q[DW-1:0]};
      4'd6: alu = a_q + p_q;
      default: ;
    endcase
  end

  wire       wr_en  = is_mvi || (is_op && (d1op == 3'd1 || d1op == 3'd2 || d1op == 3'd3));
  wire [3:0] wr_dst = is_mvi ? ins[29:26] : d1dst;
  logic [DW-1:0] wr_val;
  always_comb begin
    if (is_mvi)              wr_val = DW'(ins[25:0]);
    else if (d1op == 3'd1)   wr_val = rd_d;
    else if (d1op == 3'd2)   wr_val = DW'(imm8);
    else                     wr_val = alu[DW-1:0];
  end

  logic [3:0] touch;
  always_comb begin
    for (int n = 0; n < 4; n++)
      touch[n] = (is_op && ((xen && xs == 2'(n)) || (yen && ys == 2'(n)) ||
                            (d1op == 3'd1 && d1src == 2'(n)))) ||
                 (wr_en && wr_dst == 4'(n));
  end

  wire hold  = rpt_q && lop_q != '0;
  wire taken = is_ctl && (csub == 3'd0 || (csub == 3'd1 && xfer_busy) ||
                          (csub == 3'd2 && !xfer_busy));
  wire [PAW-1:0] npc = taken ? ins[PAW-1:0] : pc_q + 1'b1;

  always_ff @(posedge clk) begin
    if (prog_we && !run_q) imem[prog_addr] <= prog_data;
    if (run_q) begin
      if (wr_en && wr_dst[3:2] == 2'b00) ram[wr_dst[1:0]][ct_q[wr_dst[1:0]]] <= wr_val;
    end else if (host_we) begin
      ram[host_bank][host_addr] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
      rpt_q  <= 1'b0;
      pc_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
      p_q    <= '0;
      a_q    <= '0;
      lop_q  <= '0;
      ra_q   <= '0;
      xcnt_q <= '0;
      for (int n = 0; n < 4; n++) ct_q[n] <= '0;
    end else begin
      irq_q <= 1'b0;
      if (!run_q) begin
        if (start) begin
          run_q <= 1'b1;
          pc_q  <= '0;
          rpt_q <= 1'b0;
        end
      end else begin
        pc_q <= hold ? pc_q : npc;
        if (is_ctl && csub == 3'd3 && !rpt_q) rpt_q <= 1'b1;
        else if (rpt_q && !hold)              rpt_q <= 1'b0;
        if (is_ctl && (csub == 3'd4 || csub == 3'd5)) begin
          run_q <= 1'b0;
          irq_q <= csub == 3'd5;
        end
      end

      for (int n = 0; n < 4; n++) begin
        if (wr_en && wr_dst == 4'(4 + n)) ct_q[n] <= wr_val[AW-1:0];
        else if (touch[n])                ct_q[n] <= ct_q[n] + 1'b1;
      end

      if (wr_en && wr_dst == 4'd8) x_q <= wr_val;
      else if (is_op && xen)       x_q <= rd_x;
      if (wr_en && wr_dst == 4'd9) y_q <= wr_val;
      else if (is_op && yen)       y_q <= rd_y;

      if (is_op && pld) p_q <= prod;
      if (is_op && actl == 2'd1)      a_q <= alu;
      else if (is_op && actl == 2'd2) a_q <= '0;

      if (run_q && hold)               lop_q <= lop_q - 1'b1;
      else if (wr_en && wr_dst == 4'd10) lop_q <= wr_val[LW-1:0];

      if (xfer_busy) begin
        ra_q   <= ra_q + 1'b1;
        xcnt_q <= xcnt_q - 1'b1;
      end else begin
        if (wr_en && wr_dst == 4'd11) ra_q <= wr_val[RAW-1:0];
        if (is_ctl && csub == 3'd6)   xcnt_q <= imm8;
      end
    end
  end

  assign host_rdata    = ram[host_bank][host_addr];
  assign running       = run_q;
  assign irq           = irq_q;
  assign ext_byte_addr = {ra_q, 2'b00};
endmodule

// File: rtl/mac_dsp_core_chk.sv
module mac_dsp_core_chk #(
  parameter int AW  = 6,
  parameter int PAW = 6,
  parameter int LW  = 8,
  parameter int RAW = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           running,
  input logic           irq,
  input logic           xfer_busy,
  input logic [RAW+1:0] ext_byte_addr,
  input logic [PAW-1:0] pc,
  input logic           rpt,
  input logic [LW-1:0]  lop,
  input logic [4*AW-1:0] ct_all
);
  a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r12_irq_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!running && $past(running)));

  a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> ext_byte_addr == ($past(ext_byte_addr) + (RAW+2)'(4)));

  a_r9_repeat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && rpt && lop != '0) |=> (pc == $past(pc) && lop == $past(lop) - 1'b1));

  a_r2_idle_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(ct_all));
endmodule

bind mac_dsp_core mac_dsp_core_chk #(.AW(AW), .PAW(PAW), .LW(LW), .RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .irq(irq), .xfer_busy(xfer_busy),
  .ext_byte_addr(ext_byte_addr), .pc(pc_q), .rpt(rpt_q), .lop(lop_q),
  .ct_all({ct_q[3], ct_q[2], ct_q[1], ct_q[0]}));

// File: tb/mac_dsp_core_tb.sv
module mac_dsp_core_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        prog_we = 0;
  logic [5:0]  prog_addr = 0;
  logic [31:0] prog_data = 0;
  logic        host_we = 0;
  logic [1:0]  host_bank = 0;
  logic [5:0]  host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic        running, irq, xfer_busy;
  logic [25:0] ext_byte_addr;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] pg [64];
  int plen;

  always #4 clk = ~clk;

  mac_dsp_core u_dut (.*);

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] opw(int alu, int xe, int xb, int ye, int yb, int pl,
                                      int ac, int d1, int dst, int src, int imm);
    return {2'b00, 4'(alu), 1'(xe), 2'(xb), 1'(ye), 2'(yb), 1'(pl), 2'(ac), 3'(d1),
            4'(dst), 2'(src), 8'(imm)};
  endfunction
  function automatic logic [31:0] mvi(int dst, int imm);
    return {2'b01, 4'(dst), 26'(imm)};
  endfunction
  function automatic logic [31:0] ctl(int kind, int arg);
    return {2'b10, 3'(kind), 19'd0, 8'(arg)};
  endfunction

  task automatic load_prog();
    for (int i = 0; i < plen; i++) begin
      @(negedge clk); prog_we = 1; prog_addr = 6'(i); prog_data = pg[i];
    end
    @(negedge clk); prog_we = 0;
  endtask

  task automatic hw(int b, int a, logic [31:0] d);
    @(negedge clk); host_we = 1; host_bank = 2'(b); host_addr = 6'(a); host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic hr(int b, int a, output logic [31:0] d);
    @(negedge clk); host_bank = 2'(b); host_addr = 6'(a);
    #1 d = host_rdata;
  endtask

  task automatic run_prog(output int cyc, output bit saw);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 0; saw = 0;
    do begin
      @(negedge clk); cyc++;
      if (irq) saw = 1;
    end while (running && cyc < 5000);
    chk("R12 program stops", longint'(running), 0);
  endtask

  initial begin
    int cyc;
    bit saw;
    logic [31:0] v;
    int vals [7] = '{-2, -1, 0, 1, 2, 46341, -70001};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 running", longint'(running), 0);
    chk("R1 irq", longint'(irq), 0);
    chk("R1 busy", longint'(xfer_busy), 0);
    chk("R1 addr", longint'(ext_byte_addr), 0);

    // R3 R4 R5 R6 R7: constants 2,3,4,5 loaded by program then streamed
    pg[0] = mvi(4, 0); pg[1] = mvi(5, 0);
    pg[2] = mvi(0, 2); pg[3] = mvi(1, 3); pg[4] = mvi(0, 4); pg[5] = mvi(1, 5);
    pg[6] = mvi(4, 0); pg[7] = mvi(5, 0); pg[8] = mvi(6, 0);
    pg[9]  = opw(0, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    pg[10] = opw(0, 1, 0, 1, 1, 1, 2, 0, 0, 0, 0);
    pg[11] = opw(6, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    pg[12] = opw(6, 0, 0, 0, 0, 0, 0, 3, 2, 0, 0);
    pg[13] = ctl(5, 0);
    plen = 14;
    load_prog();
    run_prog(cyc, saw);
    hr(2, 0, v); chk("R6 2x3+4x5", longint'(v), 26);
    hr(0, 0, v); chk("R3 bank0 word0", longint'(v), 2);
    hr(0, 1, v); chk("R2 bank0 word1", longint'(v), 4);
    hr(1, 1, v); chk("R2 bank1 word1", longint'(v), 5);
    chk("R12 irq pulse on ENDI", longint'(saw), 1);

    // R4 R5 R6 R7 signed sweep with host-loaded operands
    pg[0] = mvi(4, 0); pg[1] = mvi(5, 0); pg[2] = mvi(6, 0);
    pg[3] = opw(0, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    pg[4] = opw(0, 1, 0, 1, 1, 1, 2, 0, 0, 0, 0);
    pg[5] = opw(6, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    pg[6] = opw(6, 0, 0, 0, 0, 0, 0, 3, 2, 0, 0);
    pg[7] = ctl(5, 0);
    plen = 8;
    load_prog();
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++)
        for (int k = 0; k < 7; k++)
          for (int l = 0; l < 7; l++) begin
            longint e;
            hw(0, 0, 32'(vals[i])); hw(1, 0, 32'(vals[j]));
            hw(0, 1, 32'(vals[k])); hw(1, 1, 32'(vals[l]));
            hw(2, 0, 32'hFFFF_FFFF);
            run_prog(cyc, saw);
            e = longint'(vals[i]) * vals[j] + longint'(vals[k]) * vals[l];
            hr(2, 0, v);
            chk("R4 R5 R6 R7 signed sum of products", longint'(v), e & 64'hFFFF_FFFF);
          end

    // R8 ALU codes on low halves
    for (int op = 0; op < 7; op++)
      for (int t = 0; t < 3; t++) begin
        int a, b;
        longint e;
        a = (t == 0) ? 'h3A5C3F1 : (t == 1) ? 'h0F0F0F0 : 'h0000123;
        b = (t == 0) ? 'h0F0F0F0 : (t == 1) ? 'h3FFFFFF : 'h2000000;
        pg[0] = mvi(6, 0); pg[1] = mvi(8, a); pg[2] = mvi(9, 1);
        pg[3] = opw(0, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0);
        pg[4] = opw(4, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        pg[5] = mvi(8, b);
        pg[6] = opw(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        pg[7] = opw(op, 0, 0, 0, 0, 0, 0, 3, 2, 0, 0);
        pg[8] = ctl(4, 0);
        plen = 9;
        load_prog();
        run_prog(cyc, saw);
        case (op)
          1: e = a & b;
          2: e = a | b;
          3: e = a ^ b;
          4, 6: e = longint'(a) + b;
          5: e = longint'(a) - b;
          default: e = a;
        endcase
        hr(2, 0, v);
        chk("R8 ALU code result", longint'(v), e & 64'hFFFF_FFFF);
        chk("R12 END gives no irq", longint'(saw), 0);
      end

    // R9 repeated copy bank0 -> bank1 starting at word 5
    for (int t = 0; t < 4; t++) begin
      int n;
      n = (t == 0) ? 1 : (t == 1) ? 2 : (t == 2) ? 5 : 12;
      for (int i = 0; i < 64; i++) begin
        hw(0, i, 32'(i * 7 + 100));
        hw(1, i, 32'hDEAD_0000 + 32'(i));
      end
      pg[0] = mvi(4, 0); pg[1] = mvi(5, 5); pg[2] = mvi(10, n - 1);
      pg[3] = ctl(3, 0);
      pg[4] = opw(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
      pg[5] = ctl(4, 0);
      plen = 6;
      load_prog();
      run_prog(cyc, saw);
      chk("R9 run length count+5", longint'(cyc), longint'(n + 5));
      for (int i = 0; i < 64; i++) begin
        hr(1, i, v);
        if (i >= 5 && i < 5 + n) chk("R9 R2 copied word", longint'(v), longint'(i - 5) * 7 + 100);
        else chk("R9 untouched word", longint'(v), 64'hDEAD_0000 + longint'(i));
      end
    end

    // R2 pointer wrap, R3 constant into port, R4 8-bit constant move
    pg[0] = mvi(7, 63); pg[1] = mvi(3, 'h111); pg[2] = mvi(3, 'h222);
    pg[3] = opw(0, 0, 0, 0, 0, 0, 0, 2, 3, 0, 'hA5);
    pg[4] = ctl(4, 0);
    plen = 5;
    load_prog();
    run_prog(cyc, saw);
    hr(3, 63, v); chk("R2 word 63", longint'(v), 'h111);
    hr(3, 0, v);  chk("R2 wrap to 0", longint'(v), 'h222);
    hr(3, 1, v);  chk("R4 constant move", longint'(v), 'hA5);

    // R11 unconditional jump and jump-if-idle
    hw(3, 10, 0);
    pg[0] = mvi(7, 10); pg[1] = ctl(0, 3); pg[2] = mvi(3, 99);
    pg[3] = ctl(2, 5); pg[4] = mvi(3, 77); pg[5] = mvi(3, 55);
    pg[6] = ctl(5, 0);
    plen = 7;
    load_prog();
    run_prog(cyc, saw);
    hr(3, 10, v); chk("R11 jumps skip words", longint'(v), 55);
    chk("R11 run length", longint'(cyc), 5);

    // R10 R11 R13 transfer stub and busy spin
    for (int t = 0; t < 5; t++) begin
      int c, base;
      c = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 3 : (t == 3) ? 5 : 20;
      base = 'h1000 + c * 16;
      hw(3, 7, 32'h0000_1234);
      pg[0] = mvi(11, base); pg[1] = ctl(6, c); pg[2] = ctl(1, 2); pg[3] = ctl(5, 0);
      plen = 4;
      load_prog();
      fork
        run_prog(cyc, saw);
        begin
          repeat (3) @(negedge clk);
          host_we = 1; host_bank = 3; host_addr = 7; host_wdata = 32'hBAD0_BAD0;
          @(negedge clk); host_we = 0;
        end
      join
      chk("R11 spin run length", longint'(cyc), longint'(c + 4));
      chk("R10 byte address", longint'(ext_byte_addr), longint'(base + c) * 4);
      chk("R10 busy cleared", longint'(xfer_busy), 0);
      hr(3, 7, v); chk("R13 host write ignored while running", longint'(v), 'h1234);
    end

    // R10 load of transfer address ignored while busy
    pg[0] = mvi(11, 'h40); pg[1] = ctl(6, 4); pg[2] = mvi(11, 'h900);
    pg[3] = ctl(1, 3); pg[4] = ctl(4, 0);
    plen = 5;
    load_prog();
    run_prog(cyc, saw);
    chk("R10 address load ignored while busy", longint'(ext_byte_addr), longint'('h44) * 4);

    summary();
    $finish;
  end
endmodule